// File: doc/BRIEF.md
# Resolver Angle Tracking Loop

This block is the digital core of a tracking angle converter. Each clock it receives a sampled and already demodulated pair of words, the sine and the cosine of a shaft angle. It keeps its own estimate of that angle in an up/down counter. It compares the input with the estimate by forming the sine of their difference, then filters that error with a second-order loop: an integrator plus a proportional path. The filtered value is a velocity. The velocity is added every clock into a signed phase accumulator. Each time the accumulator passes its positive or negative limit, the counter moves by exactly one LSB up or down.

The angle word is always valid and can be read at any time. No start pulse or handshake is needed. Each counter move is flagged by a one-cycle step strobe, with a direction bit beside it. The velocity word is signed and tells the host how fast and in which direction the shaft turns. Because the loop has two integrators, its settled lag at a constant shaft speed is zero, apart from a one-LSB dither.

Top module: `rtrk_tracker`

## Requirements
- R1: While reset is held, and in the cycles after it until the first step, `angle_o` is 0 and `step_o` is 0. The integrator and the accumulator are cleared, so with a zero-error input (sine 0, cosine positive) `vel_o` reads 0.
- R2: `angle_o` changes only in a cycle where `step_o` is 1. It moves by +1 when `dir_o` is 1 and by -1 when `dir_o` is 0, modulo 2^ANGLE_W. When `step_o` is 0 it holds.
- R3: The loop error is sinθ·cosφ − cosθ·sinφ, where φ is the counter angle. For a held input angle, `angle_o` settles within ±1 LSB of that angle.
- R4: For an input turning at a constant rate below one LSB per clock, `angle_o` settles within ±1 LSB of the input angle, with no growing lag.
- R5: `vel_o` is two's complement. It is positive for an increasing angle and negative for a decreasing one, and it settles near rate × 2^(NCO_W−1), where rate is in LSB per clock. An up step is always preceded by a positive `vel_o`, and a down step by a negative one.
- R6: At most one step happens per clock. `vel_o` is clamped to ±(2^(NCO_W−1) − 1), and it reaches that clamp for large errors.
- R7: Stepping up from all-ones gives 0, and stepping down from 0 gives all-ones.
- R8: `angle_o` is natural binary with the MSB worth a half turn. An input of a half turn settles at 2^(ANGLE_W−1).
- R9: A reset applied while the loop is moving clears the angle and the strobe. After release the loop acquires the input again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sin_i | input | SC_W | Signed sine of the input angle |
| cos_i | input | SC_W | Signed cosine of the input angle |
| angle_o | output | ANGLE_W | Tracked angle, natural binary, MSB = half turn |
| step_o | output | 1 | High for the one cycle in which `angle_o` has just moved |
| dir_o | output | 1 | Direction of the last step: 1 up, 0 down |
| vel_o | output | NCO_W | Signed velocity word from the loop filter |

## Verification
The bench builds the tracker with ANGLE_W=10, SC_W=16, NCO_W=13, a proportional shift of 2 and an integral shift of 9. With a 1024-position circle, a ramp of 1/16 LSB per clock crosses zero in both directions within a few thousand cycles, and the expected velocity is a round 256. The quarter-wave table then has only 257 entries. Large static jumps drive the velocity into its clamp. A reset in the middle of a ramp shows that the loop acquires the input again.

// File: rtl/rtrk_pkg.sv
package rtrk_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;

  typedef struct packed {
    logic      fire;
    step_dir_e dir;
  } step_t;

endpackage

// File: rtl/rtrk_sine_rom.sv
module rtrk_sine_rom #(
  parameter int ANGLE_W = 12,
  parameter int SC_W    = 16
) (
  input  logic [ANGLE_W-1:0]     phase_i,
  output logic signed [SC_W-1:0] sine_o
);

  localparam int QBITS = ANGLE_W - 2;
  localparam int QN    = 1 << QBITS;
  localparam int AMP   = (1 << (SC_W - 1)) - 1;

  function automatic logic [SC_W-2:0] mag_at(int k);
    real r;
    r = $sin(1.5707963267948966 * real'(k) / real'(QN)) * real'(AMP);
    return (SC_W-1)'($rtoi(r + 0.5));
  endfunction

  // one quadrant of magnitudes, including the end point at a quarter turn
  logic [SC_W-2:0] rom [QN+1];

  for (genvar k = 0; k <= QN; k++) begin : g_rom
    assign rom[k] = mag_at(k);
  end

  logic [1:0]       quad;
  logic [QBITS-1:0] off;
  logic [QBITS:0]   idx;
  logic [SC_W-2:0]  mag;

  always_comb begin
    quad = phase_i[ANGLE_W-1 -: 2];
    off  = phase_i[QBITS-1:0];
    // odd quadrants read the table backwards
    idx  = quad[0] ? ((QBITS+1)'(QN) - {1'b0, off}) : {1'b0, off};
    mag  = rom[idx];
    // lower half turn positive, upper half negative
    sine_o = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/rtrk_loop_filter.sv
module rtrk_loop_filter #(
  parameter int ERR_W = 17,
  parameter int NCO_W = 13,
  parameter int KP_SH = 2,
  parameter int KI_SH = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [NCO_W-1:0] vel_o
);

  localparam int BASE_W = (NCO_W + KI_SH > ERR_W) ? (NCO_W + KI_SH) : ERR_W;
  localparam int INT_W  = BASE_W + 1;
  localparam longint IMAX_L = (64'sd1 <<< (NCO_W - 1 + KI_SH)) - 1;
  localparam longint VMAX_L = (64'sd1 <<< (NCO_W - 1)) - 1;
  localparam logic signed [INT_W-1:0] IMAX = INT_W'(IMAX_L);
  localparam logic signed [INT_W-1:0] VMAX = INT_W'(VMAX_L);

  logic signed [INT_W-1:0] integ_q, integ_d, integ_sum;
  logic signed [INT_W-1:0] vel_sum, vel_c;

  // integrator keeps KI_SH fraction bits so small errors still accumulate
  always_comb begin
    integ_sum = integ_q + INT_W'(err_i);
    if (integ_sum > IMAX)       integ_d = IMAX;
    else if (integ_sum < -IMAX) integ_d = -IMAX;
    else                        integ_d = integ_sum;

    vel_sum = (integ_q >>> KI_SH) + (INT_W'(err_i) >>> KP_SH);
    if (vel_sum > VMAX)       vel_c = VMAX;
    else if (vel_sum < -VMAX) vel_c = -VMAX;
    else                      vel_c = vel_sum;
    vel_o = NCO_W'(vel_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) integ_q <= '0;
    else        integ_q <= integ_d;
  end

endmodule

// File: rtl/rtrk_nco.sv
module rtrk_nco
  import rtrk_pkg::*;
#(
  parameter int NCO_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [NCO_W-1:0] vel_i,
  output step_t                   step_o
);

  localparam logic signed [NCO_W:0] LIM = {2'b01, {(NCO_W-1){1'b0}}};

  logic signed [NCO_W-1:0] acc_q, acc_d;
  logic signed [NCO_W:0]   sum;

  always_comb begin
    sum    = {acc_q[NCO_W-1], acc_q} + {vel_i[NCO_W-1], vel_i};
    step_o = '{fire: 1'b0, dir: DIR_DOWN};
    acc_d  = NCO_W'(sum);
    if (sum >= LIM) begin
      acc_d  = NCO_W'(sum - LIM);
      step_o = '{fire: 1'b1, dir: DIR_UP};
    end else if (sum <= -LIM) begin
      acc_d  = NCO_W'(sum + LIM);
      step_o = '{fire: 1'b1, dir: DIR_DOWN};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // velocity from the filter never reaches the accumulator limit
  AST_VEL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    vel_i != {1'b1, {(NCO_W-1){1'b0}}}); // R6

endmodule

// File: rtl/rtrk_angle_ctr.sv
module rtrk_angle_ctr
  import rtrk_pkg::*;
#(
  parameter int ANGLE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  step_t              step_i,
  output logic [ANGLE_W-1:0] angle_o,
  output logic               strobe_o,
  output logic               dir_o
);

  logic [ANGLE_W-1:0] ang_q, ang_d;
  logic               stb_q, stb_d, dir_q, dir_d;

  always_comb begin
    ang_d = ang_q;
    dir_d = dir_q;
    stb_d = step_i.fire;
    if (step_i.fire) begin
      dir_d = (step_i.dir == DIR_UP);
      ang_d = (step_i.dir == DIR_UP) ? ang_q + ANGLE_W'(1) : ang_q - ANGLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ang_q <= '0;
      stb_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      ang_q <= ang_d;
      stb_q <= stb_d;
      dir_q <= dir_d;
    end
  end

  assign angle_o  = ang_q;
  assign strobe_o = stb_q;
  assign dir_o    = dir_q;

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(ang_q)); // R2
  AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && dir_q) |-> (ang_q == $past(ang_q) + ANGLE_W'(1))); // R2
  AST_STEP_DN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !dir_q) |-> (ang_q == $past(ang_q) - ANGLE_W'(1))); // R2
  AST_WRAP_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && dir_q && ($past(ang_q) == '1)) |-> (ang_q == '0)); // R7

endmodule

// File: rtl/rtrk_tracker.sv
module rtrk_tracker
  import rtrk_pkg::*;
#(
  parameter int ANGLE_W = 12,
  parameter int SC_W    = 16,
  parameter int NCO_W   = 13,
  parameter int KP_SH   = 2,
  parameter int KI_SH   = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SC_W-1:0]  sin_i,
  input  logic signed [SC_W-1:0]  cos_i,
  output logic [ANGLE_W-1:0]      angle_o,
  output logic                    step_o,
  output logic                    dir_o,
  output logic signed [NCO_W-1:0] vel_o
);

  localparam int ERR_W = SC_W + 1;
  localparam int QN    = 1 << (ANGLE_W - 2);
  localparam int PW    = 2 * SC_W;

  // reset: asserted at once, released after two clock edges
  logic rst_q1, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_int <= rst_q1;
    end
  end

  // sine (g=0) and cosine (g=1) of the counter angle
  logic signed [SC_W-1:0] trig [2];
  for (genvar g = 0; g < 2; g++) begin : g_trig
    logic [ANGLE_W-1:0] ph;
    assign ph = angle_o + ANGLE_W'(g * QN);
    rtrk_sine_rom #(.ANGLE_W(ANGLE_W), .SC_W(SC_W)) u_rom (
      .phase_i (ph),
      .sine_o  (trig[g])
    );
  end

  // error = sin(theta)cos(phi) - cos(theta)sin(phi)
  logic signed [PW-1:0]    prod_a, prod_b;
  logic signed [PW:0]      diff;
  logic signed [ERR_W-1:0] err;

  always_comb begin
    prod_a = sin_i * trig[1];
    prod_b = cos_i * trig[0];
    diff   = (PW+1)'(prod_a) - (PW+1)'(prod_b);
    err    = ERR_W'(diff >>> (SC_W - 1));
  end

  step_t step_w;

  rtrk_loop_filter #(.ERR_W(ERR_W), .NCO_W(NCO_W), .KP_SH(KP_SH), .KI_SH(KI_SH)) u_filt (
    .clk   (clk),
    .rst_n (rst_int),
    .err_i (err),
    .vel_o (vel_o)
  );

  rtrk_nco #(.NCO_W(NCO_W)) u_nco (
    .clk    (clk),
    .rst_n  (rst_int),
    .vel_i  (vel_o),
    .step_o (step_w)
  );

  rtrk_angle_ctr #(.ANGLE_W(ANGLE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int),
    .step_i   (step_w),
    .angle_o  (angle_o),
    .strobe_o (step_o),
    .dir_o    (dir_o)
  );

  always @(posedge clk) begin
    if (!rst_int) begin
      AST_RESET_ZERO: assert (angle_o == '0 && !step_o); // R1
    end
  end

  AST_UP_POS_VEL: assert property (@(posedge clk) disable iff (!rst_int)
    (step_o && dir_o) |-> ($past(vel_o) > 0)); // R5
  AST_DN_NEG_VEL: assert property (@(posedge clk) disable iff (!rst_int)
    (step_o && !dir_o) |-> ($past(vel_o) < 0)); // R5

endmodule

// File: tb/rtrk_tracker_tb_top.sv
module rtrk_tracker_tb_top;

  localparam int AW   = 10;
  localparam int SW   = 16;
  localparam int NW   = 13;
  localparam int FULL = 1 << AW;
  localparam int LIM  = 1 << (NW - 1);
  localparam real AMPL = 31000.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [SW-1:0] sin_i = '0;
  logic signed [SW-1:0] cos_i = '0;
  logic [AW-1:0]        angle_o;
  logic                 step_o, dir_o;
  logic signed [NW-1:0] vel_o;

  always #5 clk = ~clk;

  rtrk_tracker #(.ANGLE_W(AW), .SC_W(SW), .NCO_W(NW), .KP_SH(2), .KI_SH(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .sin_i(sin_i), .cos_i(cos_i),
    .angle_o(angle_o), .step_o(step_o), .dir_o(dir_o), .vel_o(vel_o)
  );

  typedef struct {
    string tag;
    int    kind;   // 0 angle (circular), 1 velocity, 2 step strobe
    int    expv;
    int    tol;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0, n_bad = 0;
  real  th = 0.0;
  int   bad_step = 0, wraps_up = 0, wraps_dn = 0, vmax = 0;

  function automatic int circ(int d);
    int m;
    m = ((d % FULL) + FULL) % FULL;
    return (m >= FULL / 2) ? m - FULL : m;
  endfunction

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(string tag, int act, int expv, int tol, bit circular);
    int d;
    n_chk++;
    d = circular ? circ(act - expv) : act - expv;
    if (d > tol || d < -tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d tol=%0d", tag, act, expv, tol);
    end
  endtask

  task automatic drive();
    real a;
    a = 2.0 * 3.141592653589793 * th / real'(FULL);
    sin_i = SW'(rnd(AMPL * $sin(a)));
    cos_i = SW'(rnd(AMPL * $cos(a)));
  endtask

  task automatic run(int n, real rate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      th = th + rate;
      if (th >= real'(FULL)) th = th - real'(FULL);
      if (th < 0.0) th = th + real'(FULL);
      drive();
    end
  endtask

  task automatic push(string tag, int kind, int expv, int tol);
    exp_t it;
    it.tag = tag; it.kind = kind; it.expv = expv; it.tol = tol;
    sb_q.push_back(it);
  endtask

  function automatic int th_lsb();
    return rnd(th) % FULL;
  endfunction

  // monitor: step-rule tracking and scoreboard comparison, away from the edge
  initial begin
    exp_t it;
    int   prev = 0;
    bit   prev_ok = 1'b0;
    int   a, v, d;
    forever begin
      @(posedge clk);
      #2;
      a = int'(angle_o);
      v = int'(vel_o);
      if (rst_n && prev_ok) begin
        d = circ(a - prev);
        if (step_o) begin
          if (d != (dir_o ? 1 : -1)) bad_step++;
        end else if (d != 0) begin
          bad_step++;
        end
        if (prev == FULL - 1 && a == 0) wraps_up++;
        if (prev == 0 && a == FULL - 1) wraps_dn++;
      end
      if ((v < 0 ? -v : v) > vmax) vmax = (v < 0 ? -v : v);
      prev    = a;
      prev_ok = rst_n;
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        case (it.kind)
          0:       check(it.tag, a, it.expv, it.tol, 1'b1);
          1:       check(it.tag, v, it.expv, it.tol, 1'b0);
          default: check(it.tag, int'(step_o), it.expv, 0, 1'b0);
        endcase
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    th = 0.0;
    drive();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: cleared state, zero error input gives zero velocity
    push("R1 angle in reset", 0, 0, 0);
    push("R1 velocity in reset", 1, 0, 0);
    push("R1 strobe in reset", 2, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 angle just after release", 0, 0, 0);

    // R3: static angle acquisition
    th = 300.0; drive();
    run(20000, 0.0);
    push("R3 static angle 300", 0, 300, 1);

    // R8: half turn lands on MSB alone
    th = 512.0; drive();
    run(15000, 0.0);
    push("R8 half turn reads MSB", 0, FULL / 2, 1);

    // R4/R5: ramp up, crossing zero (R7)
    for (int k = 0; k < 6; k++) begin
      run(1500, 1.0 / 16.0);
      if (k >= 2) begin
        push("R4 ramp up lag", 0, th_lsb(), 1);
        push("R5 ramp up velocity", 1, LIM / 16, 80);
      end
    end

    // R4/R5: ramp down, crossing zero the other way (R7)
    for (int k = 0; k < 8; k++) begin
      run(1500, -1.0 / 16.0);
      if (k >= 2) begin
        push("R4 ramp down lag", 0, th_lsb(), 1);
        push("R5 ramp down velocity", 1, -(LIM / 16), 80);
      end
    end
    @(negedge clk);
    check("R7 wrap up through zero seen", (wraps_up > 0) ? 1 : 0, 1, 0, 1'b0);
    check("R7 wrap down through zero seen", (wraps_dn > 0) ? 1 : 0, 1, 0, 1'b0);

    // R6: large jump saturates velocity
    vmax = 0;
    th = th + 400.0;
    if (th >= real'(FULL)) th = th - real'(FULL);
    drive();
    run(20000, 0.0);
    push("R3 static after large jump", 0, th_lsb(), 1);
    @(negedge clk);
    check("R6 velocity never beyond clamp", vmax, LIM - 1, 0, 1'b0);

    // R9: reset while moving
    run(500, 1.0 / 16.0);
    rst_n = 1'b0;
    @(negedge clk);
    push("R9 angle cleared by reset", 0, 0, 0);
    push("R9 strobe cleared by reset", 2, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run(20000, 0.0);
    push("R9 reacquire after reset", 0, th_lsb(), 1);
    repeat (3) @(negedge clk);

    check("R2 R6 single-LSB steps only with strobe", bad_step, 0, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule